// File: doc/BRIEF.md
# Address and PC Breakpoint Comparator

This block watches the processor's instruction address and its operand addresses and raises a one-cycle trigger toward the halt controller when either one meets a programmed condition. Software programs a pair of address bounds, a PC reference and a PC mask, and sets the enable bits. The comparator then evaluates every cycle in which a valid strobe is high.

The address side has three modes that share the same two bound registers. The first fires when the operand address equals the lower bound. The second fires when the address lies inside the bounds, with both ends included. The third fires when the address lies outside the bounds. The PC side compares the instruction address with a reference, ignores the bits that the mask selects, and can be inverted so that it fires for execution outside the region. Any mix of enabled conditions is combined with OR into one registered pulse.

Top module: `bkpt_cmp`

## Requirements
- R1: While `rst_n` is low, `trig` is 0. After reset, `trig` stays 0 until a qualifying condition has been seen.
- R2: When `en_eq`, `en_in`, `en_out` and `pc_en` are all 0, no address value produces a trigger.
- R3: With `en_eq` set, a valid operand address equal to `lo_bound` triggers. Any other address does not trigger through this mode.
- R4: With `en_in` set, a valid operand address A triggers when `lo_bound <= A <= hi_bound`. Both ends are included.
- R5: With `en_out` set, a valid operand address A triggers when `A < lo_bound` or `A > hi_bound`. A value equal to either bound does not trigger.
- R6: When several enabled conditions are true, any one of them triggers. This applies to several address modes together and to the address side together with the PC side.
- R7: With `pc_en` set and `pc_inv` clear, a valid PC triggers when `((pc ^ pc_ref) & ~pc_mask) == 0`. A mask bit of 1 means that bit is not compared.
- R8: With `pc_en` and `pc_inv` both set, a valid PC triggers only when the masked compare of R7 fails. When `pc_en` is clear, `pc_inv` has no effect.
- R9: An address condition counts only while `op_vld` is 1. A PC condition counts only while `pc_vld` is 1.
- R10: `trig` is registered. It is 1 for exactly the one cycle after each qualifying cycle and is 0 after a cycle that does not qualify.
- R11: All comparisons treat addresses as unsigned `AW`-bit values. For example, 32'h8000_0000 is greater than 32'h7FFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_bound | input | AW | Lower address bound, also the equality value |
| hi_bound | input | AW | Upper address bound |
| pc_ref | input | AW | PC reference address |
| pc_mask | input | AW | PC mask; 1 = bit ignored |
| en_eq | input | 1 | Enable the equal-to-lower-bound mode |
| en_in | input | 1 | Enable the inclusive in-range mode |
| en_out | input | 1 | Enable the outside-range mode |
| pc_en | input | 1 | Enable the PC breakpoint |
| pc_inv | input | 1 | Fire when the PC is outside the masked region |
| pc_vld | input | 1 | PC strobe |
| pc | input | AW | Instruction address |
| op_vld | input | 1 | Operand address strobe |
| op_addr | input | AW | Operand address |
| trig | output | 1 | Registered breakpoint pulse |

## Verification
The bench builds the block with the default width AW = 32. This makes the sign bit of a full processor address reachable, so bounds that straddle 32'h8000_0000 show whether the comparison is unsigned. Exact-bound addresses, and addresses one below or one above each bound, test the inclusive and exclusive edges of every mode. A mask that covers only the low byte separates the compared bits from the ignored ones.

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lo_bound,
  input  logic [AW-1:0] hi_bound,
  input  logic [AW-1:0] pc_ref,
  input  logic [AW-1:0] pc_mask,
  input  logic          en_eq,
  input  logic          en_in,
  input  logic          en_out,
  input  logic          pc_en,
  input  logic          pc_inv,
  input  logic          pc_vld,
  input  logic [AW-1:0] pc,
  input  logic          op_vld,
  input  logic [AW-1:0] op_addr,
  output logic          trig
);

  logic below_lo, above_hi, at_lo;
  logic addr_hit, pc_region, pc_hit;

  assign at_lo    = (op_addr == lo_bound);
  assign below_lo = (op_addr <  lo_bound);
  assign above_hi = (op_addr >  hi_bound);

  assign addr_hit = op_vld & ((en_eq  & at_lo)
                            | (en_in  & ~below_lo & ~above_hi)
                            | (en_out & (below_lo | above_hi)));

  assign pc_region = ~|((pc ^ pc_ref) & ~pc_mask);
  assign pc_hit    = pc_vld & pc_en & (pc_region ^ pc_inv);

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= addr_hit | pc_hit;
  end

endmodule

module bkpt_cmp_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] lo_bound,
  input logic [AW-1:0] hi_bound,
  input logic [AW-1:0] pc_ref,
  input logic [AW-1:0] pc_mask,
  input logic          en_eq,
  input logic          en_in,
  input logic          en_out,
  input logic          pc_en,
  input logic          pc_inv,
  input logic          pc_vld,
  input logic [AW-1:0] pc,
  input logic          op_vld,
  input logic [AW-1:0] op_addr,
  input logic          trig
);

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> !trig);

  a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_eq && !en_in && !en_out && !pc_en) |=> !trig);

  a_r3_eq_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && en_eq && op_addr == lo_bound) |=> trig);

  a_r4_range_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && en_in && op_addr >= lo_bound && op_addr <= hi_bound) |=> trig);

  a_r5_outside_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && en_out && (op_addr < lo_bound || op_addr > hi_bound)) |=> trig);

  a_r7_pc_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_vld && pc_en && !pc_inv && ((pc ^ pc_ref) & ~pc_mask) == '0) |=> trig);

  a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_vld && !pc_vld) |=> !trig);

endmodule

bind bkpt_cmp bkpt_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_bound(lo_bound), .hi_bound(hi_bound),
  .pc_ref(pc_ref), .pc_mask(pc_mask), .en_eq(en_eq), .en_in(en_in),
  .en_out(en_out), .pc_en(pc_en), .pc_inv(pc_inv), .pc_vld(pc_vld),
  .pc(pc), .op_vld(op_vld), .op_addr(op_addr), .trig(trig)
);

// File: tb/test_bkpt_cmp.sv
module test_bkpt_cmp;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] pref;
    logic [31:0] pmask;
    logic [4:0]  ctl;   // {pc_inv, pc_en, en_out, en_in, en_eq}
    logic        pv;
    logic [31:0] pcv;
    logic        ov;
    logic [31:0] oa;
    logic        ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    // R2: everything disabled
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00000, 1'b1, 32'h4000, 1'b1, 32'h1000, 1'b0, 8'd2},
    // R3: equality mode
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00001, 1'b0, 32'h0, 1'b1, 32'h1000, 1'b1, 8'd3},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00001, 1'b0, 32'h0, 1'b1, 32'h1001, 1'b0, 8'd3},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00001, 1'b0, 32'h0, 1'b1, 32'h1800, 1'b0, 8'd3},
    // R4: inclusive range
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00010, 1'b0, 32'h0, 1'b1, 32'h1000, 1'b1, 8'd4},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00010, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 8'd4},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00010, 1'b0, 32'h0, 1'b1, 32'h0FFF, 1'b0, 8'd4},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00010, 1'b0, 32'h0, 1'b1, 32'h2001, 1'b0, 8'd4},
    // R5: outside range
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00100, 1'b0, 32'h0, 1'b1, 32'h0FFF, 1'b1, 8'd5},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00100, 1'b0, 32'h0, 1'b1, 32'h2001, 1'b1, 8'd5},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00100, 1'b0, 32'h0, 1'b1, 32'h1000, 1'b0, 8'd5},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00100, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b0, 8'd5},
    // R6: several modes and both sides ORed
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00101, 1'b0, 32'h0, 1'b1, 32'h1000, 1'b1, 8'd6},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00101, 1'b0, 32'h0, 1'b1, 32'h3000, 1'b1, 8'd6},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00101, 1'b0, 32'h0, 1'b1, 32'h1800, 1'b0, 8'd6},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b01001, 1'b1, 32'h40AB, 1'b1, 32'h1800, 1'b1, 8'd6},
    // R7: masked PC match
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b01000, 1'b1, 32'h40AB, 1'b0, 32'h0, 1'b1, 8'd7},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b01000, 1'b1, 32'h4100, 1'b0, 32'h0, 1'b0, 8'd7},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b01000, 1'b1, 32'hC000, 1'b0, 32'h0, 1'b0, 8'd7},
    // R8: inverted PC match
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b11000, 1'b1, 32'h4100, 1'b0, 32'h0, 1'b1, 8'd8},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b11000, 1'b1, 32'h40AB, 1'b0, 32'h0, 1'b0, 8'd8},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b10000, 1'b1, 32'h4100, 1'b0, 32'h0, 1'b0, 8'd8},
    // R9: strobes gate both sides
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b00001, 1'b0, 32'h0, 1'b0, 32'h1000, 1'b0, 8'd9},
    '{32'h1000, 32'h2000, 32'h4000, 32'hFF, 5'b01000, 1'b0, 32'h40AB, 1'b0, 32'h0, 1'b0, 8'd9},
    // R11: unsigned compare around the sign bit
    '{32'h7FFFFFFF, 32'h80000001, 32'h0, 32'h0, 5'b00010, 1'b0, 32'h0, 1'b1, 32'h80000000, 1'b1, 8'd11},
    '{32'h7FFFFFFF, 32'h80000001, 32'h0, 32'h0, 5'b00100, 1'b0, 32'h0, 1'b1, 32'hFFFFFFFF, 1'b1, 8'd11},
    '{32'h7FFFFFFF, 32'h80000001, 32'h0, 32'h0, 5'b00100, 1'b0, 32'h0, 1'b1, 32'h00000001, 1'b1, 8'd11},
    '{32'h7FFFFFFF, 32'h80000001, 32'h0, 32'h0, 5'b00010, 1'b0, 32'h0, 1'b1, 32'hFFFFFFFF, 1'b0, 8'd11}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] lo_bound, hi_bound, pc_ref, pc_mask, pc, op_addr;
  logic          en_eq, en_in, en_out, pc_en, pc_inv, pc_vld, op_vld;
  logic          trig;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bkpt_cmp #(.AW(AW)) i_bkpt_cmp (
    .clk(clk), .rst_n(rst_n), .lo_bound(lo_bound), .hi_bound(hi_bound),
    .pc_ref(pc_ref), .pc_mask(pc_mask), .en_eq(en_eq), .en_in(en_in),
    .en_out(en_out), .pc_en(pc_en), .pc_inv(pc_inv), .pc_vld(pc_vld),
    .pc(pc), .op_vld(op_vld), .op_addr(op_addr), .trig(trig)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (trig !== exp) begin
      n_fail++;
      $display("FAIL %s: trig=%b expected %b at %0t", req, trig, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    lo_bound = v.lo; hi_bound = v.hi; pc_ref = v.pref; pc_mask = v.pmask;
    {pc_inv, pc_en, en_out, en_in, en_eq} = v.ctl;
    pc_vld = v.pv; pc = v.pcv; op_vld = v.ov; op_addr = v.oa;
  endtask

  task automatic idle();
    op_vld = 1'b0; pc_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply(VECS[1]);
    @(negedge clk);
    @(negedge clk);
    check(1'b0, "R1 held in reset with a hit on the inputs");
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 idle after reset");

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check(VECS[i].ex, $sformatf("R%0d vector %0d", VECS[i].rq, i));
    end

    // R10: single pulse for a single qualifying cycle
    idle();
    @(negedge clk);
    check(1'b0, "R10 quiet before pulse");
    apply(VECS[1]);
    #1 check(1'b0, "R10 no combinational output");
    @(negedge clk);
    idle();
    check(1'b1, "R10 pulse one cycle later");
    @(negedge clk);
    check(1'b0, "R10 pulse lasts one cycle");

    // R10: back-to-back qualifying cycles keep trig high
    apply(VECS[16]);
    @(negedge clk);
    apply(VECS[4]);
    check(1'b1, "R10 first of two");
    @(negedge clk);
    idle();
    check(1'b1, "R10 second of two");
    @(negedge clk);
    check(1'b0, "R10 falls after run");

    // R1: reset mid-run clears the pulse
    apply(VECS[1]);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 reset overrides hit");
    rst_n = 1'b1;
    idle();
    @(negedge clk);
    check(1'b0, "R1 quiet after second reset");

    finish_run();
  end
endmodule